// File: doc/BRIEF.md
# Register Interlock Stall Detector

This block decides whether the instruction sitting in the decode stage of a five-stage in-order pipeline must be held back. The pipeline has no forwarding paths, so a register value becomes readable only after the instruction producing it has left writeback. Until then, any older instruction still in execute, memory or writeback that will write a register the decode instruction reads blocks that decode instruction. The block compares the two decode source specifiers against the destination specifier of each of those three stages. Each comparison counts only when the decode instruction actually uses that source and the older instruction actually writes its destination.

One condition overrides the hazard. When the instruction in execute is a conditional branch that is taken, the instruction in decode came down the wrong path and will be squashed. Holding it would only delay the redirect, so the stall is forced low. The block is purely combinational and the pipeline control uses its output in the same cycle.

Top module: `hazard_interlock`

## Requirements
- R1: With `useSrc1` high, `stall` is high when `srcRegA` is nonzero and equals the destination of at least one later stage whose write enable is high, unless R7 applies.
- R2: With `useSrc2` high, `stall` is high when `srcRegB` is nonzero and equals the destination of at least one later stage whose write enable is high, unless R7 applies.
- R3: Execute, memory and writeback are each checked on their own. A match in any one of them is enough to raise `stall`, and the result is the OR over both sources and all three stages.
- R4: A later stage with its write enable low never contributes a hazard, whatever its destination value. A bubble in a stage therefore never stalls decode.
- R5: A source whose read enable is low never contributes a hazard, whatever its specifier value.
- R6: Register 0 is hardwired. A source specifier of 0 never produces a hazard, even when a writing stage targets register 0.
- R7: `stall` is low whenever the execute instruction is a taken branch. This means opcode 6'h04 (branch-if-zero) with `zeroExe` high, or opcode 6'h05 (branch-if-nonzero) with `zeroExe` low.
- R8: A branch opcode that is not taken (6'h04 with `zeroExe` low, or 6'h05 with `zeroExe` high), and any other opcode, leaves the hazard result unmasked.
- R9: `stall` is combinational. It follows the inputs in the same cycle and holds no state.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcRegA | input | 5 | First source specifier of the decode instruction |
| srcRegB | input | 5 | Second source specifier of the decode instruction |
| useSrc1 | input | 1 | Decode instruction reads its first source |
| useSrc2 | input | 1 | Decode instruction reads its second source |
| dstExe | input | 5 | Destination specifier of the execute instruction |
| wrExe | input | 1 | Execute instruction writes its destination |
| dstMem | input | 5 | Destination specifier of the memory instruction |
| wrMem | input | 1 | Memory instruction writes its destination |
| dstWb | input | 5 | Destination specifier of the writeback instruction |
| wrWb | input | 1 | Writeback instruction writes its destination |
| opcodeExe | input | 6 | Opcode of the execute instruction |
| zeroExe | input | 1 | Zero flag of the execute operand |
| stall | output | 1 | Hold the decode instruction this cycle |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between any input and `stall`. The bench applies each input set just after a rising edge and samples `stall` at the following falling edge. This gives the combinational path half a period to settle and keeps sampling away from the active edge. A near-exhaustive sweep over a small register range is compared with a hazard value computed arithmetically in the bench. Directed cases then use high register numbers and the single-stage matches that the individual requirements call out.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  parameter int REG_W     = 5;
  parameter int OPC_W     = 6;
  parameter int NUM_LATER = 3;

  localparam logic [OPC_W-1:0] OPC_BR_ZERO    = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BR_NONZERO = 6'h05;

  typedef struct packed {
    logic branchTaken;
    logic src1Chk;
    logic src2Chk;
  } hzStrobe_t;
endpackage

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
(
  input  logic [OPC_W-1:0] opcodeExe,
  input  logic             zeroExe,
  input  logic             useSrc1,
  input  logic             useSrc2,
  output hzStrobe_t        strobes
);
  logic isBrZero;
  logic isBrNonZero;

  always_comb begin
    isBrZero    = (opcodeExe == OPC_BR_ZERO);
    isBrNonZero = (opcodeExe == OPC_BR_NONZERO);
    strobes.branchTaken = (isBrZero && zeroExe) || (isBrNonZero && !zeroExe);
    strobes.src1Chk     = useSrc1;
    strobes.src2Chk     = useSrc2;
  end

  // R7/R8: a taken indication only ever comes from one of the two branch opcodes
  always_comb begin
    if (strobes.branchTaken)
      assert_taken_is_branch_R7: assert (opcodeExe[OPC_W-1:1] == OPC_BR_ZERO[OPC_W-1:1])
        else $error("taken strobe raised for a non-branch opcode");
  end
endmodule

// File: rtl/hazard_datapath.sv
module hazard_datapath
  import hazard_pkg::*;
#(
  parameter int RW = hazard_pkg::REG_W,
  parameter int NL = hazard_pkg::NUM_LATER
) (
  input  logic [RW-1:0]         srcRegA,
  input  logic [RW-1:0]         srcRegB,
  input  logic [NL-1:0][RW-1:0] dstVec,
  input  logic [NL-1:0]         wrVec,
  input  hzStrobe_t             strobes,
  output logic                  stall
);
  localparam logic [RW-1:0] HARD_ZERO = '0;

  logic [NL-1:0] hitA;
  logic [NL-1:0] hitB;
  logic          srcALive;
  logic          srcBLive;
  logic          rawHazard;

  assign srcALive = strobes.src1Chk && (srcRegA != HARD_ZERO);
  assign srcBLive = strobes.src2Chk && (srcRegB != HARD_ZERO);

  for (genvar g = 0; g < NL; g++) begin : g_stage
    assign hitA[g] = srcALive && wrVec[g] && (dstVec[g] == srcRegA);
    assign hitB[g] = srcBLive && wrVec[g] && (dstVec[g] == srcRegB);
  end

  assign rawHazard = (|hitA) || (|hitB);
  assign stall     = rawHazard && !strobes.branchTaken;

  always_comb begin
    if (wrVec == '0)
      assert_no_writer_R4: assert (!stall) else $error("stall with no writing stage");
    if (!strobes.src1Chk && !strobes.src2Chk)
      assert_no_reader_R5: assert (!stall) else $error("stall with no source read");
    if (srcRegA == HARD_ZERO && srcRegB == HARD_ZERO)
      assert_reg_zero_R6: assert (!stall) else $error("stall on register 0 only");
  end
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
  import hazard_pkg::*;
#(
  parameter int REG_WIDTH = hazard_pkg::REG_W
) (
  input  logic [REG_WIDTH-1:0] srcRegA,
  input  logic [REG_WIDTH-1:0] srcRegB,
  input  logic                 useSrc1,
  input  logic                 useSrc2,
  input  logic [REG_WIDTH-1:0] dstExe,
  input  logic                 wrExe,
  input  logic [REG_WIDTH-1:0] dstMem,
  input  logic                 wrMem,
  input  logic [REG_WIDTH-1:0] dstWb,
  input  logic                 wrWb,
  input  logic [OPC_W-1:0]     opcodeExe,
  input  logic                 zeroExe,
  output logic                 stall
);
  hzStrobe_t                           strobes;
  logic [NUM_LATER-1:0][REG_WIDTH-1:0] dstVec;
  logic [NUM_LATER-1:0]                wrVec;

  assign dstVec = {dstWb, dstMem, dstExe};
  assign wrVec  = {wrWb, wrMem, wrExe};

  hazard_ctrl u_ctrl (
    .opcodeExe (opcodeExe),
    .zeroExe   (zeroExe),
    .useSrc1   (useSrc1),
    .useSrc2   (useSrc2),
    .strobes   (strobes)
  );

  hazard_datapath #(.RW(REG_WIDTH), .NL(NUM_LATER)) u_dp (
    .srcRegA (srcRegA),
    .srcRegB (srcRegB),
    .dstVec  (dstVec),
    .wrVec   (wrVec),
    .strobes (strobes),
    .stall   (stall)
  );

  always_comb begin
    if (strobes.branchTaken)
      assert_branch_mask_R7: assert (!stall) else $error("stall under taken branch");
  end
endmodule

// File: tb/tb_hazard_interlock.sv
module tb_hazard_interlock;
  logic       clk = 1'b0;
  logic [4:0] srcRegA, srcRegB, dstExe, dstMem, dstWb;
  logic       useSrc1, useSrc2, wrExe, wrMem, wrWb, zeroExe;
  logic [5:0] opcodeExe;
  logic       stall;
  int         total = 0;
  int         bad = 0;
  int         cycles = 0;

  always #10 clk = ~clk;

  hazard_interlock dut (
    .srcRegA(srcRegA), .srcRegB(srcRegB), .useSrc1(useSrc1), .useSrc2(useSrc2),
    .dstExe(dstExe), .wrExe(wrExe), .dstMem(dstMem), .wrMem(wrMem),
    .dstWb(dstWb), .wrWb(wrWb), .opcodeExe(opcodeExe), .zeroExe(zeroExe),
    .stall(stall)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic model();
    logic h = 1'b0;
    logic tk;
    if (useSrc1 && srcRegA != 0)
      h |= (wrExe && dstExe == srcRegA) || (wrMem && dstMem == srcRegA) || (wrWb && dstWb == srcRegA);
    if (useSrc2 && srcRegB != 0)
      h |= (wrExe && dstExe == srcRegB) || (wrMem && dstMem == srcRegB) || (wrWb && dstWb == srcRegB);
    tk = (opcodeExe == 6'h04 && zeroExe) || (opcodeExe == 6'h05 && !zeroExe);
    return h && !tk;
  endfunction

  task automatic setIn(input logic [4:0] a, input logic [4:0] b, input logic r1, input logic r2,
                       input logic [4:0] de, input logic we, input logic [4:0] dm, input logic wm,
                       input logic [4:0] dw, input logic ww, input logic [5:0] op, input logic z);
    @(posedge clk); #1;
    srcRegA = a; srcRegB = b; useSrc1 = r1; useSrc2 = r2;
    dstExe = de; wrExe = we; dstMem = dm; wrMem = wm; dstWb = dw; wrWb = ww;
    opcodeExe = op; zeroExe = z;
  endtask

  task automatic check(input string req, input logic exp);
    @(negedge clk);
    total++;
    if (stall !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, stall, exp);
    end
  endtask

  initial begin
    // R9 reset-like idle state: nothing read, nothing written
    setIn(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 6'h00, 0); check("R9 idle", 1'b0);
    // R1 each stage alone, high register number (R3)
    setIn(31, 0, 1, 0, 31, 1, 3, 0, 4, 0, 6'h00, 0); check("R1 exe", 1'b1);
    setIn(31, 0, 1, 0, 2, 1, 31, 1, 4, 0, 6'h00, 0); check("R3 mem", 1'b1);
    setIn(31, 0, 1, 0, 2, 1, 3, 1, 31, 1, 6'h00, 0); check("R3 wb", 1'b1);
    // R2 source two
    setIn(0, 17, 0, 1, 9, 0, 17, 1, 9, 1, 6'h00, 0); check("R2 mem", 1'b1);
    // R4 matching destination, write disabled everywhere
    setIn(17, 17, 1, 1, 17, 0, 17, 0, 17, 0, 6'h00, 0); check("R4 bubbles", 1'b0);
    // R5 matching destination, source not read
    setIn(12, 12, 0, 0, 12, 1, 12, 1, 12, 1, 6'h00, 0); check("R5 no read", 1'b0);
    // R6 register 0
    setIn(0, 0, 1, 1, 0, 1, 0, 1, 0, 1, 6'h00, 0); check("R6 reg0", 1'b0);
    // R7 taken branches mask
    setIn(5, 0, 1, 0, 5, 1, 0, 0, 0, 0, 6'h04, 1); check("R7 brz taken", 1'b0);
    setIn(5, 0, 1, 0, 5, 1, 0, 0, 0, 0, 6'h05, 0); check("R7 brnz taken", 1'b0);
    // R8 not-taken branches do not mask
    setIn(5, 0, 1, 0, 5, 1, 0, 0, 0, 0, 6'h04, 0); check("R8 brz not taken", 1'b1);
    setIn(5, 0, 1, 0, 5, 1, 0, 0, 0, 0, 6'h05, 1); check("R8 brnz not taken", 1'b1);
    // R9 changes follow within the same cycle
    setIn(5, 0, 1, 0, 6, 1, 0, 0, 0, 0, 6'h00, 0); check("R9 drop", 1'b0);

    for (int br = 0; br < 6; br++)
      for (int rr = 0; rr < 4; rr++)
        for (int ww = 0; ww < 8; ww++)
          for (int sa = 0; sa < 3; sa++)
            for (int sb = 0; sb < 3; sb++)
              for (int de = 0; de < 3; de++)
                for (int dm = 0; dm < 3; dm++)
                  for (int dw = 0; dw < 3; dw++) begin
                    logic [5:0] op;
                    string tag;
                    op = (br < 2) ? 6'h04 : (br < 4) ? 6'h05 : 6'h21;
                    setIn(sa[4:0], sb[4:0], rr[0], rr[1], de[4:0], ww[0], dm[4:0], ww[1],
                          dw[4:0], ww[2], op, br[0]);
                    tag = ((op == 6'h04 && br[0]) || (op == 6'h05 && !br[0])) ? "R7 sweep" :
                          (op != 6'h21) ? "R8 sweep" : "R3 sweep";
                    check(tag, model());
                  end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule